// File: doc/BRIEF.md
# Paravirtual Device Register Interface (Legacy Layout)

This block is the register file a guest driver talks to when it sets up a paravirtual network or storage device in the older, fixed register layout. It sits behind a simple address/data slave bus that carries byte, halfword and word accesses with the data right-justified. It holds the offered and accepted feature words, a queue selector with per-queue page-frame and vector state, a notify doorbell, the device status byte and the interrupt status byte. It also holds a small byte-addressed window of device configuration.

When message-signalled interrupts are switched on from outside (`msix_en`), two 16-bit vector registers appear at the start of the device-specific region and push the configuration window four bytes higher. Queue and configuration-change events from the device back end are routed either to a message request carrying the programmed vector, or to the interrupt status byte and a level legacy interrupt line. Reading the status byte clears it and drops the line. Ring processing, DMA and the vector table live elsewhere. This block only presents the vector number of each queue.

Top module: `pvr_regif`

## Requirements
- R1: After reset the guest feature word, queue select, status and interrupt status read 0, `irq_legacy`, `msi_req`, `notify_valid` and `dev_reset` are low, every queue is inactive, and the config vector and every queue vector hold 0xFFFF. Offset 0 reads the `HOST_FEATURES` parameter.
- R2: Registers sit at fixed byte offsets with fixed widths: 0 offered features (32, read-only), 4 accepted features (32), 8 queue page frame (32), 12 queue size (16, read-only), 14 queue select (16), 16 notify (16, write-only), 18 status (8), 19 interrupt status (8). `bus_size` codes are 0 byte, 1 halfword, 2 word. An access whose size differs from the register width does nothing and reads 0.
- R3: Writing a nonzero page frame activates the selected queue. Writing 0 deactivates it and clears its page frame. For a selected queue below `NUM_QUEUES`, queue size reads `QUEUE_SIZE`.
- R4: With queue select at or above `NUM_QUEUES`, queue size and page frame read 0, the queue vector reads 0xFFFF, and page-frame and queue-vector writes change no queue.
- R5: A halfword write to offset 16 produces a one-cycle `notify_valid` in the next cycle with `notify_idx` equal to the written value. Other sizes at offset 16 produce nothing.
- R6: A byte write of 0 to the status register pulses `dev_reset` for one cycle. It clears the accepted features, queue select, all queue state and interrupt status, and sets every vector to 0xFFFF. The configuration window keeps its contents.
- R7: While `msix_en` is high, offset 20 is the config vector and offset 22 is the vector of the selected queue (both halfword), and the configuration window starts at offset 24. While it is low, the window starts at offset 20.
- R8: The configuration window holds `CFG_BYTES` bytes. A 1, 2 or 4-byte access starting at any window offset covers consecutive bytes, lowest address in the lowest data byte. Bytes beyond the window read 0 and writes to them are dropped.
- R9: A byte read at offset 19 returns the interrupt status and clears it in the same access, so `irq_legacy` is low in the next cycle unless a new event arrives in that cycle.
- R10: A queue event (valid index) whose vector is 0xFFFF, or any queue event while `msix_en` is low, sets interrupt-status bit 0. A configuration event in the same situation sets bit 1. `irq_legacy` is high whenever the interrupt status is nonzero.
- R11: An event with a vector other than 0xFFFF while `msix_en` is high raises `msi_req` for one cycle in the next cycle with `msi_vec` equal to that vector, and leaves the interrupt status unchanged.
- R12: When queue and configuration events both need a message in the same cycle, the queue vector is issued first and the config vector in the following cycle.
- R13: `queue_vectors` shows the vector of queue q in bits [16q+15:16q].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| msix_en | input | 1 | Message interrupts enabled |
| queue_evt | input | 1 | Queue event pulse from back end |
| queue_evt_idx | input | 16 | Queue index of the event |
| config_evt | input | 1 | Configuration-change event pulse |
| irq_legacy | output | 1 | Level legacy interrupt |
| msi_req | output | 1 | Message interrupt request pulse |
| msi_vec | output | 16 | Vector of the message request |
| notify_valid | output | 1 | Doorbell pulse |
| notify_idx | output | 16 | Queue index written to the doorbell |
| dev_reset | output | 1 | Device reset pulse |
| queue_active | output | NUM_QUEUES | One bit per queue with nonzero page frame |
| queue_vectors | output | 16*NUM_QUEUES | Vector number of each queue |

## Verification
The checker watches every cycle for the doorbell pulse following exactly the halfword writes to offset 16 with the same index, and for the interrupt line falling only after a status read or a device reset. It also checks that a status read with no new event drops the line, that a status-zero write leaves all queues idle with no interrupt pending, and that unvectored events raise the line. The address layout shift under `msix_en`, the byte packing and edges of the configuration window, the out-of-range queue select, the message ordering of simultaneous events and the read values of each register are shown only by the bench's directed scenarios.

// File: rtl/pvr_pkg.sv
// Shared constants and types for the paravirtual register interface.
// Offsets are fixed because the guest driver decodes them.
package pvr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } pvr_size_e;

    localparam int unsigned OFS_HOST_FEAT  = 0;
    localparam int unsigned OFS_GUEST_FEAT = 4;
    localparam int unsigned OFS_PFN        = 8;
    localparam int unsigned OFS_QSIZE      = 12;
    localparam int unsigned OFS_QSEL       = 14;
    localparam int unsigned OFS_NOTIFY     = 16;
    localparam int unsigned OFS_STATUS     = 18;
    localparam int unsigned OFS_ISR        = 19;
    localparam int unsigned OFS_DEV_REGION = 20;
    localparam int unsigned OFS_CFG_VEC    = 20;
    localparam int unsigned OFS_Q_VEC      = 22;
    localparam int unsigned VEC_REGS_BYTES = 4;

    localparam logic [15:0] NO_VECTOR = 16'hFFFF;

    // Number of bytes moved by an access of the given size code.
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    size_bytes = 3'd1;
            2'd1:    size_bytes = 3'd2;
            2'd2:    size_bytes = 3'd4;
            default: size_bytes = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/pvr_queue_bank.sv
// Per-queue page frame and vector storage.
// Assumes writes arrive only for an in-range selected queue (the top
// gates them); reads for an out-of-range select return idle values.
module pvr_queue_bank
    import pvr_pkg::*;
#(
    parameter int NUM_QUEUES = 8,
    parameter int QIDX_W     = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_rst,
    input  logic                     sel_ok,
    input  logic [QIDX_W-1:0]        sel_idx,
    input  logic                     pfn_we,
    input  logic [31:0]              pfn_wdata,
    input  logic                     vec_we,
    input  logic [15:0]              vec_wdata,
    input  logic                     evt_ok,
    input  logic [QIDX_W-1:0]        evt_idx,
    output logic [31:0]              pfn_rd,
    output logic [15:0]              vec_rd,
    output logic [15:0]              evt_vec,
    output logic [NUM_QUEUES-1:0]    active,
    output logic [16*NUM_QUEUES-1:0] vec_flat
);

    logic [31:0] pfn_q [NUM_QUEUES];
    logic [15:0] vec_q [NUM_QUEUES];

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
        // Hold page frame and vector of queue q.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                pfn_q[q] <= '0;
                vec_q[q] <= NO_VECTOR;
            end else begin
                if (pfn_we && sel_idx == QIDX_W'(q)) pfn_q[q] <= pfn_wdata;
                if (vec_we && sel_idx == QIDX_W'(q)) vec_q[q] <= vec_wdata;
            end
        end
        assign active[q]              = (pfn_q[q] != '0);
        assign vec_flat[16*q +: 16]   = vec_q[q];
    end

    // Read port for the selected queue.
    always_comb begin
        pfn_rd = '0;
        vec_rd = NO_VECTOR;
        for (int q = 0; q < NUM_QUEUES; q++) begin
            if (sel_ok && sel_idx == QIDX_W'(q)) begin
                pfn_rd = pfn_q[q];
                vec_rd = vec_q[q];
            end
        end
    end

    // Read port for the queue raising an event.
    always_comb begin
        evt_vec = NO_VECTOR;
        for (int q = 0; q < NUM_QUEUES; q++) begin
            if (evt_ok && evt_idx == QIDX_W'(q)) evt_vec = vec_q[q];
        end
    end

endmodule

// File: rtl/pvr_cfg_window.sv
// Byte-addressed device configuration storage.
// Assumes off is relative to the window start; bytes past CFG_BYTES
// read zero and are never written.
module pvr_cfg_window #(
    parameter int ADDR_W    = 8,
    parameter int CFG_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] off,
    input  logic [2:0]        nbytes,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);

    logic [7:0] mem [CFG_BYTES];

    for (genvar k = 0; k < CFG_BYTES; k++) begin : g_byte
        logic [31:0] rel;
        logic        hit;

        // Find which data byte (if any) lands on window byte k.
        always_comb begin
            rel = 32'(k) - 32'(off);
            hit = we && (32'(off) <= 32'(k)) && (rel < 32'(nbytes));
        end

        // Store window byte k.
        always_ff @(posedge clk) begin
            if (!rst_n)   mem[k] <= '0;
            else if (hit) mem[k] <= wdata[8*rel[1:0] +: 8];
        end
    end

    // Gather up to four consecutive bytes, zero past the window.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < 4; b++) begin
            for (int k = 0; k < CFG_BYTES; k++) begin
                if (b < int'(nbytes) && 32'(off) + 32'(b) == 32'(k))
                    rdata[8*b +: 8] = mem[k];
            end
        end
    end

endmodule

// File: rtl/pvr_irq_route.sv
// Routes queue and configuration events to a message request or to
// the interrupt status byte and legacy line. Assumes events are
// single-cycle pulses. A status read clears before new events set.
module pvr_irq_route
    import pvr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        msix_en,
    input  logic        q_evt,
    input  logic [15:0] q_vec,
    input  logic        cfg_evt,
    input  logic [15:0] cfg_vec,
    input  logic        isr_clr,
    output logic [7:0]  isr,
    output logic        irq_legacy,
    output logic        msi_req,
    output logic [15:0] msi_vec
);

    logic        q_msi, q_leg, c_msi, c_leg;
    logic [7:0]  isr_n;
    logic        pend;
    logic [15:0] pend_vec;

    // Classify each event as message or legacy.
    always_comb begin
        q_msi = q_evt && msix_en && (q_vec != NO_VECTOR);
        q_leg = q_evt && !q_msi;
        c_msi = cfg_evt && msix_en && (cfg_vec != NO_VECTOR);
        c_leg = cfg_evt && !c_msi;
        isr_n = (isr_clr ? 8'h00 : isr) | {6'b0, c_leg, q_leg};
    end

    // Interrupt status byte and legacy level.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            isr        <= '0;
            irq_legacy <= 1'b0;
        end else begin
            isr        <= isr_n;
            irq_legacy <= (isr_n != 8'h00);
        end
    end

    // Message requests: queue first, config deferred one cycle on a clash.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            msi_req  <= 1'b0;
            msi_vec  <= NO_VECTOR;
            pend     <= 1'b0;
            pend_vec <= NO_VECTOR;
        end else if (q_msi) begin
            msi_req <= 1'b1;
            msi_vec <= q_vec;
            if (c_msi) begin
                pend     <= 1'b1;
                pend_vec <= cfg_vec;
            end
        end else if (c_msi) begin
            msi_req <= 1'b1;
            msi_vec <= cfg_vec;
            pend    <= 1'b0;
        end else if (pend) begin
            msi_req <= 1'b1;
            msi_vec <= pend_vec;
            pend    <= 1'b0;
        end else begin
            msi_req <= 1'b0;
        end
    end

endmodule

// File: rtl/pvr_regif.sv
// Top of the paravirtual register interface: bus decode, scalar
// registers and read multiplexer. Assumes accesses name the first
// byte of a register; reads return data combinationally in the
// access cycle and read side effects take place at its clock edge.
module pvr_regif
    import pvr_pkg::*;
#(
    parameter int          ADDR_W        = 8,
    parameter int          NUM_QUEUES    = 8,
    parameter int          CFG_BYTES     = 16,
    parameter logic [31:0] HOST_FEATURES = 32'h1003_0020,
    parameter logic [15:0] QUEUE_SIZE    = 16'd256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_req,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [1:0]               bus_size,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic                     msix_en,
    input  logic                     queue_evt,
    input  logic [15:0]              queue_evt_idx,
    input  logic                     config_evt,
    output logic                     irq_legacy,
    output logic                     msi_req,
    output logic [15:0]              msi_vec,
    output logic                     notify_valid,
    output logic [15:0]              notify_idx,
    output logic                     dev_reset,
    output logic [NUM_QUEUES-1:0]    queue_active,
    output logic [16*NUM_QUEUES-1:0] queue_vectors
);

    localparam int QIDX_W = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1;

    logic [31:0]       addr_u;
    logic              rd, wr, is_b, is_h, is_w;
    logic [2:0]        nbytes;
    logic [31:0]       win_base;
    logic              in_win;
    logic [ADDR_W-1:0] win_off;
    logic [31:0]       win_rdata;

    logic [31:0]       guest_feat;
    logic [15:0]       qsel;
    logic [7:0]        status;
    logic [15:0]       cfg_vec;
    logic [7:0]        isr;

    logic              sel_ok, evt_ok;
    logic [QIDX_W-1:0] sel_idx, evt_idx;
    logic [31:0]       pfn_rd;
    logic [15:0]       vec_rd, evt_vec;

    logic              soft_rst, isr_clr;
    logic              pfn_we, vec_we, cfgv_we, win_we, notify_we;

    // Decode the access and its address region.
    always_comb begin
        addr_u   = 32'(bus_addr);
        rd       = bus_req && !bus_wr;
        wr       = bus_req && bus_wr;
        is_b     = (pvr_size_e'(bus_size) == SZ_BYTE);
        is_h     = (pvr_size_e'(bus_size) == SZ_HALF);
        is_w     = (pvr_size_e'(bus_size) == SZ_WORD);
        nbytes   = size_bytes(bus_size);
        win_base = msix_en ? OFS_DEV_REGION + VEC_REGS_BYTES : OFS_DEV_REGION;
        in_win   = (addr_u >= win_base);
        win_off  = ADDR_W'(addr_u - win_base);
        sel_ok   = (32'(qsel) < 32'(NUM_QUEUES));
        sel_idx  = qsel[QIDX_W-1:0];
        evt_ok   = (32'(queue_evt_idx) < 32'(NUM_QUEUES));
        evt_idx  = queue_evt_idx[QIDX_W-1:0];
    end

    // Write strobes and read side effects.
    always_comb begin
        soft_rst  = wr && is_b && addr_u == OFS_STATUS && bus_wdata[7:0] == 8'h00;
        isr_clr   = rd && is_b && addr_u == OFS_ISR;
        pfn_we    = wr && is_w && addr_u == OFS_PFN && sel_ok;
        vec_we    = wr && is_h && msix_en && addr_u == OFS_Q_VEC && sel_ok;
        cfgv_we   = wr && is_h && msix_en && addr_u == OFS_CFG_VEC;
        win_we    = wr && in_win && nbytes != 3'd0;
        notify_we = wr && is_h && addr_u == OFS_NOTIFY;
    end

    // Scalar driver-visible registers and device reset handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guest_feat <= '0;
            qsel       <= '0;
            status     <= '0;
            cfg_vec    <= NO_VECTOR;
        end else if (soft_rst) begin
            guest_feat <= '0;
            qsel       <= '0;
            status     <= '0;
            cfg_vec    <= NO_VECTOR;
        end else if (wr) begin
            if (is_w && addr_u == OFS_GUEST_FEAT) guest_feat <= bus_wdata;
            if (is_h && addr_u == OFS_QSEL)       qsel       <= bus_wdata[15:0];
            if (is_b && addr_u == OFS_STATUS)     status     <= bus_wdata[7:0];
            if (cfgv_we)                          cfg_vec    <= bus_wdata[15:0];
        end
    end

    // One-cycle doorbell and reset pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            notify_valid <= 1'b0;
            notify_idx   <= '0;
            dev_reset    <= 1'b0;
        end else begin
            notify_valid <= notify_we;
            if (notify_we) notify_idx <= bus_wdata[15:0];
            dev_reset    <= soft_rst;
        end
    end

    pvr_queue_bank #(
        .NUM_QUEUES (NUM_QUEUES),
        .QIDX_W     (QIDX_W)
    ) u_queues (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .sel_ok    (sel_ok),
        .sel_idx   (sel_idx),
        .pfn_we    (pfn_we),
        .pfn_wdata (bus_wdata),
        .vec_we    (vec_we),
        .vec_wdata (bus_wdata[15:0]),
        .evt_ok    (evt_ok),
        .evt_idx   (evt_idx),
        .pfn_rd    (pfn_rd),
        .vec_rd    (vec_rd),
        .evt_vec   (evt_vec),
        .active    (queue_active),
        .vec_flat  (queue_vectors)
    );

    pvr_cfg_window #(
        .ADDR_W    (ADDR_W),
        .CFG_BYTES (CFG_BYTES)
    ) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (win_we),
        .off    (win_off),
        .nbytes (nbytes),
        .wdata  (bus_wdata),
        .rdata  (win_rdata)
    );

    pvr_irq_route u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .msix_en    (msix_en),
        .q_evt      (queue_evt && evt_ok),
        .q_vec      (evt_vec),
        .cfg_evt    (config_evt),
        .cfg_vec    (cfg_vec),
        .isr_clr    (isr_clr),
        .isr        (isr),
        .irq_legacy (irq_legacy),
        .msi_req    (msi_req),
        .msi_vec    (msi_vec)
    );

    // Read multiplexer; wrong-size or unmapped reads return zero.
    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            if (addr_u == OFS_HOST_FEAT) begin
                if (is_w) bus_rdata = HOST_FEATURES;
            end else if (addr_u == OFS_GUEST_FEAT) begin
                if (is_w) bus_rdata = guest_feat;
            end else if (addr_u == OFS_PFN) begin
                if (is_w) bus_rdata = pfn_rd;
            end else if (addr_u == OFS_QSIZE) begin
                if (is_h) bus_rdata = sel_ok ? 32'(QUEUE_SIZE) : 32'h0;
            end else if (addr_u == OFS_QSEL) begin
                if (is_h) bus_rdata = 32'(qsel);
            end else if (addr_u == OFS_STATUS) begin
                if (is_b) bus_rdata = 32'(status);
            end else if (addr_u == OFS_ISR) begin
                if (is_b) bus_rdata = 32'(isr);
            end else if (in_win) begin
                bus_rdata = win_rdata;
            end else if (addr_u == OFS_CFG_VEC) begin
                if (is_h) bus_rdata = 32'(cfg_vec);
            end else if (addr_u == OFS_Q_VEC) begin
                if (is_h) bus_rdata = 32'(vec_rd);
            end
        end
    end

endmodule

// File: rtl/pvr_regif_chk.sv
// Cycle checks on the register interface ports, bound to pvr_regif.
module pvr_regif_chk #(
    parameter int ADDR_W     = 8,
    parameter int NUM_QUEUES = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_req,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [1:0]            bus_size,
    input logic [15:0]           wdata_lo,
    input logic                  msix_en,
    input logic                  queue_evt,
    input logic [15:0]           queue_evt_idx,
    input logic                  config_evt,
    input logic                  irq_legacy,
    input logic                  msi_req,
    input logic                  notify_valid,
    input logic [15:0]           notify_idx,
    input logic                  dev_reset,
    input logic [NUM_QUEUES-1:0] queue_active
);

    logic isr_rd, notify_wr, stat0_wr, evt_legacy;

    // Port-level recognition of the accesses of interest.
    always_comb begin
        isr_rd     = bus_req && !bus_wr && 32'(bus_addr) == 32'd19 && bus_size == 2'd0;
        notify_wr  = bus_req && bus_wr && 32'(bus_addr) == 32'd16 && bus_size == 2'd1;
        stat0_wr   = bus_req && bus_wr && 32'(bus_addr) == 32'd18 && bus_size == 2'd0
                     && wdata_lo[7:0] == 8'h00;
        evt_legacy = ((queue_evt && 32'(queue_evt_idx) < 32'(NUM_QUEUES)) || config_evt)
                     && !msix_en;
    end

    assert_isr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && !queue_evt && !config_evt && !stat0_wr) |=> !irq_legacy);

    assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_legacy) |-> ($past(isr_rd) || dev_reset));

    assert_notify_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        notify_wr |=> (notify_valid && notify_idx == $past(wdata_lo)));

    assert_notify_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> $past(notify_wr));

    assert_status_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat0_wr |=> (dev_reset && queue_active == '0 && !irq_legacy && !msi_req));

    assert_legacy_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_legacy && !stat0_wr) |=> irq_legacy);

endmodule

bind pvr_regif pvr_regif_chk #(
    .ADDR_W     (ADDR_W),
    .NUM_QUEUES (NUM_QUEUES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_req       (bus_req),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_size      (bus_size),
    .wdata_lo      (bus_wdata[15:0]),
    .msix_en       (msix_en),
    .queue_evt     (queue_evt),
    .queue_evt_idx (queue_evt_idx),
    .config_evt    (config_evt),
    .irq_legacy    (irq_legacy),
    .msi_req       (msi_req),
    .notify_valid  (notify_valid),
    .notify_idx    (notify_idx),
    .dev_reset     (dev_reset),
    .queue_active  (queue_active)
);

// File: tb/pvr_regif_test.sv
`timescale 1ns/1ps
// Directed bench for pvr_regif: one task per scenario.
module pvr_regif_test;

    localparam int          NQ   = 8;
    localparam logic [31:0] HOST = 32'h1003_0020;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        msix_en = 1'b0;
    logic        queue_evt = 1'b0, config_evt = 1'b0;
    logic [15:0] queue_evt_idx = '0;
    logic        irq_legacy, msi_req, notify_valid, dev_reset;
    logic [15:0] msi_vec, notify_idx;
    logic [NQ-1:0]    queue_active;
    logic [16*NQ-1:0] queue_vectors;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pvr_regif uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .msix_en(msix_en), .queue_evt(queue_evt),
        .queue_evt_idx(queue_evt_idx), .config_evt(config_evt),
        .irq_legacy(irq_legacy), .msi_req(msi_req), .msi_vec(msi_vec),
        .notify_valid(notify_valid), .notify_idx(notify_idx),
        .dev_reset(dev_reset), .queue_active(queue_active),
        .queue_vectors(queue_vectors)
    );

    task automatic check(input string what, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    task automatic wr(input int a, input int sz, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_wr = 1; bus_addr = 8'(a); bus_size = 2'(sz); bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_wr = 0;
    endtask

    task automatic rd(input int a, input int sz, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_wr = 0; bus_addr = 8'(a); bus_size = 2'(sz);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_req = 0;
    endtask

    task automatic pulse(input bit q, input int idx, input bit c);
        @(negedge clk);
        queue_evt = q; queue_evt_idx = 16'(idx); config_evt = c;
        @(negedge clk);
        queue_evt = 0; config_evt = 0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        rd(0, 2, d);  check("R1 host features", d, HOST);
        rd(4, 2, d);  check("R1 guest features", d, 0);
        rd(18, 0, d); check("R1 status", d, 0);
        rd(19, 0, d); check("R1 isr", d, 0);
        check("R1 irq/msi/notify/reset", {irq_legacy, msi_req, notify_valid, dev_reset}, 0);
        check("R1 queues inactive", queue_active, 0);
        msix_en = 1;
        rd(20, 1, d); check("R1 config vector", d, 16'hFFFF);
        rd(22, 1, d); check("R1 queue vector", d, 16'hFFFF);
        msix_en = 0;
    endtask

    task automatic t_sizes();
        logic [31:0] d;
        wr(4, 2, 32'hDEAD_BEEF);
        rd(4, 2, d); check("R2 guest rw", d, 32'hDEAD_BEEF);
        wr(0, 2, 32'h0);
        rd(0, 2, d); check("R2 host read-only", d, HOST);
        rd(4, 0, d); check("R2 wrong-size read zero", d, 0);
        wr(4, 1, 32'h1111);
        rd(4, 2, d); check("R2 wrong-size write ignored", d, 32'hDEAD_BEEF);
    endtask

    task automatic t_queues();
        logic [31:0] d;
        wr(14, 1, 2);
        rd(12, 1, d); check("R3 queue size", d, 256);
        wr(8, 2, 32'h1234);
        check("R3 activate q2", queue_active, 8'h04);
        rd(8, 2, d); check("R3 pfn readback", d, 32'h1234);
        wr(14, 1, 5); wr(8, 2, 32'h55);
        check("R3 activate q5", queue_active, 8'h24);
        wr(14, 1, 2); wr(8, 2, 0);
        check("R3 deactivate q2", queue_active, 8'h20);
        rd(8, 2, d); check("R3 pfn cleared", d, 0);
    endtask

    task automatic t_out_of_range();
        logic [31:0] d;
        wr(14, 1, 9);
        rd(12, 1, d); check("R4 size zero", d, 0);
        wr(8, 2, 32'h77);
        check("R4 pfn write dropped", queue_active, 8'h20);
        rd(8, 2, d); check("R4 pfn read zero", d, 0);
        msix_en = 1;
        wr(22, 1, 3);
        rd(22, 1, d); check("R4 vector read none", d, 16'hFFFF);
        check("R4 vectors untouched", queue_vectors, {NQ{16'hFFFF}});
        msix_en = 0;
    endtask

    task automatic t_vector_layout();
        logic [31:0] d;
        msix_en = 1;
        wr(14, 1, 5); wr(22, 1, 4);
        rd(22, 1, d); check("R7 queue vector", d, 4);
        check("R13 vector output q5", queue_vectors[16*5 +: 16], 4);
        check("R13 vector output q4", queue_vectors[16*4 +: 16], 16'hFFFF);
        wr(20, 1, 7);
        rd(20, 1, d); check("R7 config vector", d, 7);
        wr(24, 0, 32'hA5);
        msix_en = 0;
        rd(20, 0, d); check("R7 window moves", d, 32'hA5);
    endtask

    task automatic t_window();
        logic [31:0] d;
        wr(20, 2, 32'h4433_2211);
        rd(23, 0, d); check("R8 byte lane", d, 32'h44);
        rd(21, 1, d); check("R8 halfword span", d, 32'h3322);
        wr(34, 2, 32'hCCDD_EEFF);
        rd(34, 2, d); check("R8 tail clipped", d, 32'h0000_EEFF);
        rd(36, 0, d); check("R8 beyond window", d, 0);
    endtask

    task automatic t_notify();
        wr(16, 1, 3);
        check("R5 notify pulse", {notify_valid, notify_idx}, {1'b1, 16'd3});
        @(negedge clk);
        check("R5 notify one cycle", notify_valid, 0);
        wr(16, 0, 6);
        check("R5 byte notify ignored", notify_valid, 0);
    endtask

    task automatic t_legacy_irq();
        logic [31:0] d;
        pulse(1, 5, 0);
        check("R10 queue event raises line", irq_legacy, 1);
        rd(19, 0, d); check("R9 isr value", d, 1);
        check("R9 line dropped", irq_legacy, 0);
        rd(19, 0, d); check("R9 isr cleared", d, 0);
        pulse(0, 0, 1);
        rd(19, 1, d); check("R9 wrong-size read no clear", {d, 31'b0, irq_legacy}, {32'h0, 32'h1});
        rd(19, 0, d); check("R10 config bit", d, 2);
        pulse(1, 1, 1);
        rd(19, 0, d); check("R10 both bits", d, 3);
    endtask

    task automatic t_msi();
        logic [31:0] d;
        msix_en = 1;
        pulse(1, 5, 0);
        check("R11 message", {msi_req, msi_vec, irq_legacy}, {1'b1, 16'd4, 1'b0});
        pulse(1, 2, 0);
        check("R10 unvectored queue under msix", irq_legacy, 1);
        rd(19, 0, d); check("R11 isr only bit0", d, 1);
        pulse(1, 5, 1);
        check("R12 queue first", {msi_req, msi_vec}, {1'b1, 16'd4});
        @(negedge clk);
        check("R12 config second", {msi_req, msi_vec}, {1'b1, 16'd7});
        @(negedge clk);
        check("R12 done", msi_req, 0);
        msix_en = 0;
    endtask

    task automatic t_status_reset();
        logic [31:0] d;
        wr(18, 0, 32'h0F);
        rd(18, 0, d); check("R2 status rw", d, 32'h0F);
        pulse(1, 5, 0);
        wr(18, 0, 32'h00);
        check("R6 reset pulse", {dev_reset, irq_legacy}, 2'b10);
        check("R6 queues cleared", queue_active, 0);
        check("R6 vectors none", queue_vectors, {NQ{16'hFFFF}});
        @(negedge clk);
        check("R6 pulse one cycle", dev_reset, 0);
        rd(4, 2, d);  check("R6 guest cleared", d, 0);
        rd(14, 1, d); check("R6 select cleared", d, 0);
        rd(20, 0, d); check("R6 window kept", d, 32'h11);
        msix_en = 1;
        rd(20, 1, d); check("R6 config vector none", d, 16'hFFFF);
        msix_en = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset_state();
        t_sizes();
        t_queues();
        t_out_of_range();
        t_vector_layout();
        t_window();
        t_notify();
        t_legacy_irq();
        t_msi();
        t_status_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule